// File: doc/BRIEF.md
# Fast-to-Slow Memory Access Synchronizer

This block sits between a fast CPU bus and a slow memory side that runs at one tenth-class speed: one slow cycle spans `RATIO` fast clocks. The slow memory is shared with a display refresh engine. That engine must read the memory once in every slow cycle. Each slow cycle is therefore split into two parts. The first `RATIO/2` fast clocks are the video part. The remaining fast clocks belong to the CPU. Video never has to steal a cycle.

Every accepted fast-side cycle is decoded. A cycle goes to the slow side in two cases. The first is any access to banks $E0 or $E1. The second is a write into a mirrored region of banks $00/$01. In that second case the fast RAM is written at once, and the same byte is copied to the slow side. For slow cycles the block drops `ready_o`, waits for the next CPU part of a slow cycle, and runs the slow strobes for the whole of that part. It returns `ready_o` in the following cycle. Reads of mirrored regions are served from fast RAM with no stall.

Top module: `fsb_bridge`

## Requirements
- R1: After reset, `ready_o` is 1, `slow_we_o`/`slow_re_o` are 0, `rdata_o` is 0, and `vid_stb_o` is 1.
- R2: Slow phase 0 is the first fast cycle after reset release. The phase advances by one per fast cycle modulo RATIO. `vid_stb_o` is 1 exactly in phases 0..RATIO/2-1.
- R3: `slow_we_o`/`slow_re_o` are asserted only in phases RATIO/2..RATIO-1 and never together with `vid_stb_o`.
- R4: A cycle is accepted when `req_i` and `ready_o` are both 1. Every accepted read or write with `addr_i[23:16]` equal to $E0 or $E1 goes to the slow side, and `slow_addr_o` equals `addr_i[16:0]`.
- R5: An accepted write in bank $00 or $01 goes to the slow side, with `slow_addr_o = addr_i[16:0]` and `slow_wdata_o = wdata_i`, in three cases: offset $0400–$07FF while mirror bit 0 is set; offset $2000–$5FFF while bit 1 is set; offset $C000–$CFFF while bit 2 is set. All other writes outside $E0/$E1 do not.
- R6: An accepted read outside banks $E0/$E1 never stalls: `ready_o` stays 1 in the next cycle.
- R7: A slow cycle accepted in phase p holds `ready_o` at 0 for L = ((RATIO/2 − (p+1) mod RATIO) mod RATIO) + RATIO − RATIO/2 cycles. The slow strobe is active in the last RATIO − RATIO/2 of those cycles, and `ready_o` is 1 again in the cycle after.
- R8: `fast_we_o` is 1 in the acceptance cycle exactly for writes outside banks $E0/$E1, mirrored or not.
- R9: The data on `slow_rdata_i` in the last phase of a slow read appears on `rdata_o` from the cycle `ready_o` returns.
- R10: The 3-bit mirror control resets to 3'b111. It is loaded from `shd_wdata_i` when `shd_we_i` is 1, and it governs requests accepted after that edge.
- R11: A slow request accepted in the cycle `ready_o` returns (phase 0) is served in the CPU part of that same slow cycle, so at most one slow access happens per slow cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Fast-side cycle request |
| we_i | input | 1 | Request is a write |
| addr_i | input | 24 | Request address |
| wdata_i | input | DW | Write data |
| shd_we_i | input | 1 | Load mirror control |
| shd_wdata_i | input | 3 | Mirror enables: bit0 text, bit1 hires, bit2 I/O page |
| ready_o | output | 1 | Bus ready; 0 while stalled |
| fast_we_o | output | 1 | Fast RAM write enable for this cycle |
| rdata_o | output | DW | Data from the last slow read |
| slow_addr_o | output | 17 | Slow memory address |
| slow_wdata_o | output | DW | Slow memory write data |
| slow_we_o | output | 1 | Slow write strobe |
| slow_re_o | output | 1 | Slow read strobe |
| slow_rdata_i | input | DW | Slow memory read data |
| vid_stb_o | output | 1 | Video fetch part of the slow cycle |

## Verification
If the phase counter slips, `vid_stb_o` breaks its fixed pattern within one slow cycle. Every later stall length is then off by the same amount, so the next slow request shows the error in its `ready_o` count. A wrong decode or a wrong mirror bit shows at once. A mirrored write that should stall leaves `ready_o` high in the next cycle, and a read that should not stall drops it. A stale captured address or read datum shows on `slow_addr_o` during the strobe, or on `rdata_o` when `ready_o` returns.

// File: rtl/fsb_pkg.sv
package fsb_pkg;
  localparam int ADDR_W  = 24;
  localparam int SLOW_AW = 17;
  localparam int SHD_W   = 3;

  localparam logic [7:0] BANK_SLOW0 = 8'hE0;
  localparam logic [7:0] BANK_SLOW1 = 8'hE1;
  localparam logic [7:0] BANK_MIR0  = 8'h00;
  localparam logic [7:0] BANK_MIR1  = 8'h01;

  // mirror control bit positions
  localparam int SHD_TEXT  = 0;
  localparam int SHD_HIRES = 1;
  localparam int SHD_IO    = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_XFER} fsb_state_e;

  typedef struct packed {
    logic slow_bank;
    logic need_slow;
  } fsb_dec_t;
endpackage

// File: rtl/fsb_phase.sv
module fsb_phase #(
  parameter int RATIO = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic vid_stb_o,
  output logic cpu_last_o,
  output logic cpu_first_nxt_o
);
  localparam int PHW     = (RATIO > 2) ? $clog2(RATIO) : 1;
  localparam int VID_LEN = RATIO / 2;
  localparam logic [PHW-1:0] PH_LAST = PHW'(RATIO - 1);
  localparam logic [PHW-1:0] PH_CPU  = PHW'(VID_LEN);

  generate
    if (RATIO < 2) begin : g_bad_ratio
      $error("fsb_phase: RATIO must be at least 2");
    end
  endgenerate

  logic [PHW-1:0] ph_q, ph_d;

  assign ph_d = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= '0;
    else         ph_q <= ph_d;
  end

  assign vid_stb_o       = (ph_q < PH_CPU);
  assign cpu_last_o      = (ph_q == PH_LAST);
  assign cpu_first_nxt_o = (ph_d == PH_CPU);

  AST_PH_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_LAST) |=> (ph_q == '0)); // R2
  AST_VID_EVERY_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_last_o |=> vid_stb_o); // R2
endmodule

// File: rtl/fsb_decode.sv
module fsb_decode
  import fsb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shd_we_i,
  input  logic [SHD_W-1:0]  shd_wdata_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output fsb_dec_t          dec_o
);
  logic [SHD_W-1:0] shd_q;
  logic [7:0]  bank;
  logic [15:0] off;
  logic mir_bank, hit_text, hit_hires, hit_io, mir_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       shd_q <= '1;
    else if (shd_we_i) shd_q <= shd_wdata_i;
  end

  assign bank = addr_i[23:16];
  assign off  = addr_i[15:0];

  always_comb begin
    mir_bank  = (bank == BANK_MIR0) || (bank == BANK_MIR1);
    hit_text  = (off[15:10] == 6'b000001);
    hit_hires = (off[15:13] == 3'd1) || (off[15:13] == 3'd2);
    hit_io    = (off[15:12] == 4'hC);
    mir_hit   = (hit_text  && shd_q[SHD_TEXT])  ||
                (hit_hires && shd_q[SHD_HIRES]) ||
                (hit_io    && shd_q[SHD_IO]);
    dec_o.slow_bank = (bank == BANK_SLOW0) || (bank == BANK_SLOW1);
    dec_o.need_slow = dec_o.slow_bank || (we_i && mir_bank && mir_hit);
  end

  AST_SHD_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shd_we_i |=> (shd_q == $past(shd_wdata_i))); // R10
endmodule

// File: rtl/fsb_ctrl.sv
module fsb_ctrl
  import fsb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [SLOW_AW-1:0] addr_i,
  input  logic [DW-1:0]      wdata_i,
  input  fsb_dec_t           dec_i,
  input  logic               vid_stb_i,
  input  logic               cpu_last_i,
  input  logic               cpu_first_nxt_i,
  input  logic [DW-1:0]      slow_rdata_i,
  output logic               ready_o,
  output logic               fast_we_o,
  output logic [DW-1:0]      rdata_o,
  output logic [SLOW_AW-1:0] slow_addr_o,
  output logic [DW-1:0]      slow_wdata_o,
  output logic               slow_we_o,
  output logic               slow_re_o
);
  fsb_state_e st_q, st_d;
  logic acc, take, we_q, xfer;

  assign ready_o   = (st_q == ST_IDLE);
  assign acc       = req_i && ready_o;
  assign take      = acc && dec_i.need_slow;
  assign fast_we_o = acc && we_i && !dec_i.slow_bank;
  assign xfer      = (st_q == ST_XFER);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (take) st_d = cpu_first_nxt_i ? ST_XFER : ST_WAIT;
      ST_WAIT: if (cpu_first_nxt_i) st_d = ST_XFER;
      ST_XFER: if (cpu_last_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      we_q         <= 1'b0;
      slow_addr_o  <= '0;
      slow_wdata_o <= '0;
      rdata_o      <= '0;
    end else begin
      st_q <= st_d;
      if (take) begin
        we_q         <= we_i;
        slow_addr_o  <= addr_i;
        slow_wdata_o <= wdata_i;
      end
      if (xfer && cpu_last_i && !we_q) rdata_o <= slow_rdata_i;
    end
  end

  assign slow_we_o = xfer && we_q;
  assign slow_re_o = xfer && !we_q;

  AST_STB_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vid_stb_i && (slow_we_o || slow_re_o))); // R3
  AST_STALL_ON_SLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> !ready_o); // R7
  AST_FAST_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !dec_i.need_slow) |=> ready_o); // R6
  AST_READY_AFTER_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(slow_we_o || slow_re_o) |-> ready_o); // R7
endmodule

// File: rtl/fsb_bridge.sv
module fsb_bridge
  import fsb_pkg::*;
#(
  parameter int RATIO = 3,
  parameter int DW    = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic               shd_we_i,
  input  logic [SHD_W-1:0]   shd_wdata_i,
  output logic               ready_o,
  output logic               fast_we_o,
  output logic [DW-1:0]      rdata_o,
  output logic [SLOW_AW-1:0] slow_addr_o,
  output logic [DW-1:0]      slow_wdata_o,
  output logic               slow_we_o,
  output logic               slow_re_o,
  input  logic [DW-1:0]      slow_rdata_i,
  output logic               vid_stb_o
);
  fsb_dec_t dec;
  logic cpu_last, cpu_first_nxt;

  fsb_phase #(.RATIO(RATIO)) u_phase (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .vid_stb_o       (vid_stb_o),
    .cpu_last_o      (cpu_last),
    .cpu_first_nxt_o (cpu_first_nxt)
  );

  fsb_decode u_decode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .shd_we_i    (shd_we_i),
    .shd_wdata_i (shd_wdata_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .dec_o       (dec)
  );

  fsb_ctrl #(.DW(DW)) u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_i           (req_i),
    .we_i            (we_i),
    .addr_i          (addr_i[SLOW_AW-1:0]),
    .wdata_i         (wdata_i),
    .dec_i           (dec),
    .vid_stb_i       (vid_stb_o),
    .cpu_last_i      (cpu_last),
    .cpu_first_nxt_i (cpu_first_nxt),
    .slow_rdata_i    (slow_rdata_i),
    .ready_o         (ready_o),
    .fast_we_o       (fast_we_o),
    .rdata_o         (rdata_o),
    .slow_addr_o     (slow_addr_o),
    .slow_wdata_o    (slow_wdata_o),
    .slow_we_o       (slow_we_o),
    .slow_re_o       (slow_re_o)
  );

  AST_SLOW_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slow_we_o || slow_re_o) |-> !ready_o); // R7
endmodule

// File: tb/sim_fsb_bridge.sv
`timescale 1ns/1ps
module sim_fsb_bridge;
  localparam int N  = 3;
  localparam int VL = N / 2;
  localparam int DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, shd_we = 1'b0;
  logic [23:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [2:0] shd_wdata = '0;
  logic ready, fast_we, slow_we, slow_re, vid_stb;
  logic [DW-1:0] rdata, slow_wdata, slow_rdata;
  logic [16:0] slow_addr;

  int n_chk = 0, n_fail = 0, ph_m = 0;
  bit done = 1'b0;
  logic [2:0] cfg_m = 3'b111;

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] mem_f(logic [16:0] a);
    return a[7:0] ^ a[15:8] ^ {7'd0, a[16]} ^ 8'h5A;
  endfunction
  assign slow_rdata = mem_f(slow_addr);

  fsb_bridge #(.RATIO(N), .DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .shd_we_i(shd_we), .shd_wdata_i(shd_wdata),
    .ready_o(ready), .fast_we_o(fast_we), .rdata_o(rdata),
    .slow_addr_o(slow_addr), .slow_wdata_o(slow_wdata), .slow_we_o(slow_we),
    .slow_re_o(slow_re), .slow_rdata_i(slow_rdata), .vid_stb_o(vid_stb)
  );

  // independent phase reference: phase 0 in first cycle after reset release
  always @(posedge clk or negedge rst_n)
    if (!rst_n) ph_m <= 0;
    else        ph_m <= (ph_m == N - 1) ? 0 : ph_m + 1;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(vid_stb == (ph_m < VL), "R2 video strobe phase", int'(vid_stb), int'(ph_m < VL));
    chk(!(vid_stb && (slow_we || slow_re)), "R3 strobe overlap",
        int'({slow_we, slow_re}), 0);
  end

  function automatic bit exp_slow(bit w, logic [23:0] a, logic [2:0] c);
    logic [7:0] b = a[23:16];
    logic [15:0] o = a[15:0];
    if (b == 8'hE0 || b == 8'hE1) return 1'b1;
    if (!w || !(b == 8'h00 || b == 8'h01)) return 1'b0;
    return (o >= 16'h0400 && o <= 16'h07FF && c[0]) ||
           (o >= 16'h2000 && o <= 16'h5FFF && c[1]) ||
           (o >= 16'hC000 && o <= 16'hCFFF && c[2]);
  endfunction

  // call at a negedge with ready high; returns at a negedge with ready high
  task automatic do_req(input bit w, input logic [23:0] a, input logic [DW-1:0] d);
    bit slow = exp_slow(w, a, cfg_m);
    bit sb = (a[23:16] == 8'hE0) || (a[23:16] == 8'hE1);
    int p = ph_m, L = 0, cnt = 0, nstb = 0;
    if (slow) L = ((VL - ((p + 1) % N) + N) % N) + N - VL;
    chk(ready, "R7 ready before request", int'(ready), 1);
    req = 1'b1; we = w; addr = a; wdata = d;
    #1;
    chk(fast_we == (w && !sb), "R8 fast write enable", int'(fast_we), int'(w && !sb));
    @(posedge clk); @(negedge clk);
    req = 1'b0; we = 1'b0;
    while (!ready && cnt < 3 * N) begin
      bit es = (cnt >= L - (N - VL));
      chk((slow_we || slow_re) == es, slow ? "R7 strobe position" : "R6 unexpected strobe",
          int'(slow_we || slow_re), int'(es));
      if (slow_we || slow_re) begin
        nstb++;
        chk(slow_we == w, sb ? "R4 strobe kind" : "R5 strobe kind", int'(slow_we), int'(w));
        chk(slow_addr == a[16:0], sb ? "R4 slow address" : "R5 slow address",
            int'(slow_addr), int'(a[16:0]));
        if (w) chk(slow_wdata == d, "R5 slow write data", int'(slow_wdata), int'(d));
      end
      cnt++;
      @(negedge clk);
    end
    if (slow) chk(cnt == L, sb ? "R4 stall length" : "R5 stall length", cnt, L);
    else      chk(cnt == 0, w ? "R5 no stall" : "R6 read no stall", cnt, 0);
    chk(nstb == (slow ? N - VL : 0), "R7 strobe count", nstb, slow ? N - VL : 0);
    if (slow && !w) chk(rdata == mem_f(a[16:0]), "R9 read data",
                        int'(rdata), int'(mem_f(a[16:0])));
  endtask

  task automatic set_cfg(input logic [2:0] c);
    shd_we = 1'b1; shd_wdata = c;
    @(posedge clk); @(negedge clk);
    shd_we = 1'b0; cfg_m = c;
  endtask

  function automatic logic [23:0] rnd_addr();
    logic [7:0] b;
    logic [15:0] o;
    case ($urandom % 6)
      0: b = 8'h00; 1: b = 8'h01; 2: b = 8'hE0;
      3: b = 8'hE1; 4: b = 8'h02; default: b = 8'hFF;
    endcase
    case ($urandom % 4)
      0: o = 16'h0400 + 16'($urandom % 32'h400);
      1: o = 16'h2000 + 16'($urandom % 32'h4000);
      2: o = 16'hC000 + 16'($urandom % 32'h1000);
      default: o = 16'($urandom);
    endcase
    return {b, o};
  endfunction

  initial begin
    logic [15:0] edges [12] = '{16'h03FF, 16'h0400, 16'h07FF, 16'h0800, 16'h1FFF, 16'h2000,
                                16'h5FFF, 16'h6000, 16'hBFFF, 16'hC000, 16'hCFFF, 16'hD000};
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(ready == 1'b1, "R1 reset ready", int'(ready), 1);
    chk(!slow_we && !slow_re, "R1 reset strobes", int'({slow_we, slow_re}), 0);
    chk(rdata == '0, "R1 reset rdata", int'(rdata), 0);
    chk(vid_stb == 1'b1, "R1 reset video phase", int'(vid_stb), 1);
    @(negedge clk);
    // R10 reset value: all mirrors on
    foreach (edges[i]) do_req(1'b1, {8'h00, edges[i]}, 8'(i));
    set_cfg(3'b000);
    foreach (edges[i]) do_req(1'b1, {8'h01, edges[i]}, 8'(i + 16));
    set_cfg(3'b010);
    do_req(1'b1, 24'h003000, 8'hA5); // R10 hires only
    do_req(1'b1, 24'h000500, 8'hA6);
    do_req(1'b0, 24'h003000, 8'h00); // R6 mirrored read
    // R11 back-to-back slow reads at every phase offset
    for (int k = 0; k < N; k++) begin
      do_req(1'b0, 24'hE01234 + 24'(k), 8'h00);
      do_req(1'b0, 24'hE1ABCD - 24'(k), 8'h00);
      @(negedge clk);
    end
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 16 == 0) set_cfg(3'($urandom));
      repeat ($urandom % 3) @(negedge clk);
      do_req(1'($urandom), rnd_addr(), 8'($urandom));
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule